// File: doc/BRIEF.md
# Regulator Start-Up and Protection Sequencer

This block orders the power-up and power-down of a step-down switching regulator. When the enable pin is high and no fault is present, it wakes the voltage reference, waits a fixed settling time, and then raises a digital soft-start code from zero to its full value in equal timed steps. The switching controller runs from the start of the ramp onward. At the end of the ramp a one-clock done pulse is given. While the block is off, the output-discharge path is turned on.

An undervoltage flag, an over-temperature flag (hysteresis applied outside), or a low enable pin forces the block back to off within one clock. The ramp code is cleared at the same time. When the cause goes away, a fresh wake and soft-start follow. A short-circuit flag does not stop the regulator. While the controller is running, the flag selects a slow oscillator instead.

Top module: `reg_start_seq`

## Requirements
- R1: After reset: refWake=0, rampCode=0, runEn=0, bleedEn=1, oscSlow=0, rampDone=0.
- R2: With enPin high and no fault, refWake goes high one clock later. For WAKE_CYCLES clocks it stays high while runEn=0 and rampCode=0. Only then does the ramp start.
- R3: During the ramp, runEn=1. rampCode starts at 0 and rises by exactly one every STEP_CYCLES clocks up to the full code (all CODE_W bits set), then holds there.
- R4: rampDone is high for exactly one clock. That clock is the first one in which rampCode equals the full code.
- R5: enPin low, uvloFlag high or hotFlag high, in any state, gives the off outputs of R1 one clock later.
- R6: bleedEn drops in the first clock of start-up and is never high while runEn is high.
- R7: While uvloFlag is high, the block stays off even with enPin high.
- R8: After hotFlag clears, with enPin high, start-up repeats the full wake period and the ramp from code 0.
- R9: oscSlow equals shortFlag while runEn is high and is 0 otherwise. shortFlag changes neither runEn nor rampCode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enPin | input | 1 | Regulator enable request |
| uvloFlag | input | 1 | Input supply below lockout threshold |
| hotFlag | input | 1 | Over-temperature flag, hysteresis applied |
| shortFlag | input | 1 | Output short-circuit flag |
| refWake | output | 1 | Wakes the voltage reference |
| rampCode | output | CODE_W | Soft-start reference code |
| runEn | output | 1 | Lets the switching controller run |
| bleedEn | output | 1 | Turns on the output-discharge path |
| oscSlow | output | 1 | Selects the slow oscillator frequency |
| rampDone | output | 1 | One-clock pulse at the end of the ramp |

## Verification
The state-driven outputs (refWake, runEn, bleedEn, rampCode, rampDone) change one clock edge after the input that causes the change. oscSlow follows shortFlag in the same cycle once runEn is high. For each input change, the driver queues the outputs it expects after the next rising edge. Start-up is queued as WAKE_CYCLES wake samples, then (2^CODE_W−1)·STEP_CYCLES ramp samples whose codes are the sample index divided by STEP_CYCLES, then the done sample. The monitor pops one entry a little after each rising edge, so every result is compared in exactly the clock in which it is due.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_WAKE = 2'd1,
    SEQ_RAMP = 2'd2,
    SEQ_ON   = 2'd3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clr;      // zero all counters and the code
    logic wakeRun;  // count reference settling time
    logic rampRun;  // advance the soft-start ramp
  } seqStrobe_t;
endpackage

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
  import regseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       uvloFlag,
  input  logic       hotFlag,
  input  logic       shortFlag,
  input  logic       wakeDone,
  input  logic       rampLast,
  output seqStrobe_t strobe,
  output logic       refWake,
  output logic       runEn,
  output logic       bleedEn,
  output logic       oscSlow
);
  seqState_t state, stateNext;
  logic haltReq;

  assign haltReq = !enPin || uvloFlag || hotFlag;

  always_comb begin
    stateNext = state;
    if (haltReq) begin
      stateNext = SEQ_OFF;
    end else begin
      case (state)
        SEQ_OFF:  stateNext = SEQ_WAKE;
        SEQ_WAKE: if (wakeDone) stateNext = SEQ_RAMP;
        SEQ_RAMP: if (rampLast) stateNext = SEQ_ON;
        default:  stateNext = SEQ_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_OFF;
    else       state <= stateNext;
  end

  assign strobe.clr     = haltReq || (state == SEQ_OFF);
  assign strobe.wakeRun = !haltReq && (state == SEQ_WAKE);
  assign strobe.rampRun = !haltReq && (state == SEQ_RAMP);

  assign refWake = (state != SEQ_OFF);
  assign runEn   = (state == SEQ_RAMP) || (state == SEQ_ON);
  assign bleedEn = (state == SEQ_OFF);
  assign oscSlow = runEn && shortFlag;

  AST_DISABLE_TO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> (state == SEQ_OFF)); // R5
  AST_BLEED_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(bleedEn && runEn)); // R6
  AST_WAKE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runEn) |-> $past(refWake)); // R2
  AST_SLOW_ONLY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    oscSlow |-> runEn); // R9
endmodule

// File: rtl/regseq_datapath.sv
module regseq_datapath
  import regseq_pkg::*;
#(
  parameter int WAKE_CYCLES = 10000,
  parameter int STEP_CYCLES = 784,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic              wakeDone,
  output logic              rampLast,
  output logic [CODE_W-1:0] rampCode,
  output logic              rampDone
);
  localparam int WK_W = $clog2(WAKE_CYCLES + 1);
  localparam int ST_W = $clog2(STEP_CYCLES + 1);
  localparam logic [WK_W-1:0]   WAKE_LAST = WK_W'(WAKE_CYCLES - 1);
  localparam logic [ST_W-1:0]   STEP_LAST = ST_W'(STEP_CYCLES - 1);
  localparam logic [CODE_W-1:0] CODE_FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_PRE  = CODE_FULL - 1'b1;

  logic [WK_W-1:0] wakeCnt;
  logic [ST_W-1:0] stepCnt;
  logic stepTick;

  assign stepTick = (stepCnt == STEP_LAST);
  assign wakeDone = strobe.wakeRun && (wakeCnt == WAKE_LAST);
  assign rampLast = strobe.rampRun && stepTick && (rampCode == CODE_PRE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt  <= '0;
      stepCnt  <= '0;
      rampCode <= '0;
      rampDone <= 1'b0;
    end else if (strobe.clr) begin
      wakeCnt  <= '0;
      stepCnt  <= '0;
      rampCode <= '0;
      rampDone <= 1'b0;
    end else begin
      wakeCnt  <= strobe.wakeRun ? wakeCnt + 1'b1 : '0;
      rampDone <= rampLast;
      if (strobe.rampRun) begin
        if (stepTick) begin
          stepCnt <= '0;
          if (rampCode != CODE_FULL) rampCode <= rampCode + 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end else begin
        stepCnt <= '0;
      end
    end
  end

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ((rampCode != $past(rampCode)) && (rampCode != '0))
      |-> (rampCode == CODE_W'($past(rampCode) + 1'b1))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rampDone |=> !rampDone); // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rampDone |-> (rampCode == CODE_FULL)); // R4
endmodule

// File: rtl/reg_start_seq.sv
module reg_start_seq
  import regseq_pkg::*;
#(
  parameter int WAKE_CYCLES = 10000,
  parameter int STEP_CYCLES = 784,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPin,
  input  logic              uvloFlag,
  input  logic              hotFlag,
  input  logic              shortFlag,
  output logic              refWake,
  output logic [CODE_W-1:0] rampCode,
  output logic              runEn,
  output logic              bleedEn,
  output logic              oscSlow,
  output logic              rampDone
);
  seqStrobe_t strobe;
  logic wakeDone;
  logic rampLast;

  regseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enPin     (enPin),
    .uvloFlag  (uvloFlag),
    .hotFlag   (hotFlag),
    .shortFlag (shortFlag),
    .wakeDone  (wakeDone),
    .rampLast  (rampLast),
    .strobe    (strobe),
    .refWake   (refWake),
    .runEn     (runEn),
    .bleedEn   (bleedEn),
    .oscSlow   (oscSlow)
  );

  regseq_datapath #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .STEP_CYCLES (STEP_CYCLES),
    .CODE_W      (CODE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wakeDone (wakeDone),
    .rampLast (rampLast),
    .rampCode (rampCode),
    .rampDone (rampDone)
  );
endmodule

// File: tb/reg_start_seq_bench.sv
module reg_start_seq_bench;
  localparam int W  = 4;
  localparam int S  = 3;
  localparam int CW = 3;
  localparam int M  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPin = 1'b0, uvloFlag = 1'b0, hotFlag = 1'b0, shortFlag = 1'b0;
  logic refWake, runEn, bleedEn, oscSlow, rampDone;
  logic [CW-1:0] rampCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    string req;
    int    code;
    bit    wake, run, bleed, slow, done;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  reg_start_seq #(.WAKE_CYCLES(W), .STEP_CYCLES(S), .CODE_W(CW)) u_reg_start_seq (
    .clk(clk), .rstN(rstN), .enPin(enPin), .uvloFlag(uvloFlag),
    .hotFlag(hotFlag), .shortFlag(shortFlag), .refWake(refWake),
    .rampCode(rampCode), .runEn(runEn), .bleedEn(bleedEn),
    .oscSlow(oscSlow), .rampDone(rampDone)
  );

  task automatic compareNow(expItem_t it);
    nChecks++;
    if (int'(rampCode) != it.code || refWake != it.wake || runEn != it.run ||
        bleedEn != it.bleed || oscSlow != it.slow || rampDone != it.done) begin
      nFails++;
      $display("FAIL %s: got code=%0d wake=%0b run=%0b bleed=%0b slow=%0b done=%0b, expected code=%0d wake=%0b run=%0b bleed=%0b slow=%0b done=%0b",
               it.req, rampCode, refWake, runEn, bleedEn, oscSlow, rampDone,
               it.code, it.wake, it.run, it.bleed, it.slow, it.done);
    end
  endtask

  // monitor: one expected item per rising edge while the queue holds any
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) compareNow(expQ.pop_front());
  end

  task automatic pushExp(string req, int code, bit wake, bit run, bit bleed, bit slow, bit done);
    expItem_t it;
    it.req = req; it.code = code; it.wake = wake; it.run = run;
    it.bleed = bleed; it.slow = slow; it.done = done;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic expOff(string req);
    pushExp(req, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic expOn(string req, bit slow);
    pushExp(req, M, 1, 1, 0, slow, 0);
  endtask

  task automatic startup(string wakeReq, string rampReq, bit slow);
    for (int i = 0; i < W; i++) pushExp(wakeReq, 0, 1, 0, 0, 0, 0);
    for (int j = 0; j < M * S; j++) pushExp(rampReq, j / S, 1, 1, 0, slow, 0);
    pushExp("R4", M, 1, 1, 0, slow, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    expItem_t r;
    repeat (3) @(negedge clk);
    r.req = "R1"; r.code = 0; r.wake = 0; r.run = 0; r.bleed = 1; r.slow = 0; r.done = 0;
    compareNow(r);                       // R1 reset state
    rstN = 1'b1;
    expOff("R1"); expOff("R1");
    // R7: lockout holds off despite enable
    enPin = 1'b1; uvloFlag = 1'b1;
    expOff("R7"); expOff("R7"); expOff("R7");
    // R2, R3, R4, R6: full start-up
    uvloFlag = 1'b0;
    startup("R2", "R3", 1'b0);
    expOn("R3", 1'b0); expOn("R3", 1'b0);
    // R9: short selects slow clock, run and code untouched
    shortFlag = 1'b1;
    expOn("R9", 1'b1); expOn("R9", 1'b1);
    shortFlag = 1'b0;
    expOn("R9", 1'b0);
    // R5: enable low from on
    enPin = 1'b0;
    expOff("R5"); expOff("R5");
    // R5: disable during wake
    enPin = 1'b1;
    pushExp("R2", 0, 1, 0, 0, 0, 0); pushExp("R2", 0, 1, 0, 0, 0, 0);
    enPin = 1'b0;
    expOff("R5");
    // R9 during wake is 0; R5 lockout in mid-ramp
    enPin = 1'b1; shortFlag = 1'b1;
    for (int i = 0; i < W; i++) pushExp("R9", 0, 1, 0, 0, 0, 0);
    for (int j = 0; j < 5; j++) pushExp("R9", j / S, 1, 1, 0, 1, 0);
    uvloFlag = 1'b1;
    expOff("R5"); expOff("R7");
    uvloFlag = 1'b0; shortFlag = 1'b0;
    startup("R2", "R3", 1'b0);
    expOn("R3", 1'b0);
    // R8: over-temperature then fresh restart
    hotFlag = 1'b1;
    expOff("R8"); expOff("R8"); expOff("R8");
    hotFlag = 1'b0;
    startup("R8", "R8", 1'b0);
    expOn("R8", 1'b0);
    enPin = 1'b0;
    expOff("R5");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule